// File: doc/BRIEF.md
# Interleaved Bank Command Scheduler

This block sits on the controller side of a packet-based DRAM channel. It takes read and write transactions through a valid/ready request port. Each request names a device, a row and two column addresses. The block turns each transaction into one row activate and two column commands, and places them on separate row and column command slots. Read transactions also get a precharge on an extended column field. Successive transactions are steered through a fixed rotation of four non-adjacent banks. A new transaction can therefore start every row-to-row interval (`TRR`) instead of waiting a full row cycle (`TRC`). Strobes mark where each write data packet must be driven and where each read data packet returns. All times are counted in command-slot clock cycles.

Requests are queued in a 4-entry FIFO. Back-pressure rule: `in_ready` is high exactly when the FIFO has a free entry, and a request is taken on any clock edge where `in_valid` and `in_ready` are both high. While the oldest queued request cannot issue, the FIFO fills and `in_ready` drops. A request waits when its rotation bank is still inside `TRC`, when `TRR` has not elapsed since the previous activate, or when a read-to-write turnaround bubble is still owed. The command outputs are plain strobes with no handshake. Address fields are meaningful only while their strobe is high.

Top module: `ilv_bank_sched`

## Requirements
- R1: The n-th activate after reset (n counted from 0) targets bank `BASE + 2*(n mod 4)`. It carries the device and row of the n-th accepted request, so requests are served in arrival order.
- R2: Two activates are never closer than `TRR` cycles. When requests are queued and no other limit applies, they are exactly `TRR` apart.
- R3: An activate to a bank comes no earlier than `TRC` cycles after the previous activate to that same bank.
- R4: When a write transaction follows a read transaction, `TCBUB` extra cycles are added to the spacing between their activates. Read after write, and same-direction pairs, get no extra cycles.
- R5: Each transaction issues two column commands, at `TRCD` and at `TRCD + TRR/2` cycles after its activate. They carry its device, its bank and, in order, column 1 then column 2.
- R6: For a write, the first column op is WR (code 2) and the second is WRA, write with auto-precharge (code 3). No precharge strobe is raised for it.
- R7: For a read, both column ops are RD (code 1). `pre_vld` is high with `pre_bank` equal to the read's bank in the cycle of the second column command.
- R8: `wr_go` pulses for one cycle `TCWD` cycles after each write column command. `rd_go` pulses for one cycle `TCAC` cycles after each read column command.
- R9: `in_ready` is high exactly when fewer than 4 requests are queued. From idle, the activate appears one cycle after the clock edge that accepted the request.
- R10: `col_op` reads 0 (idle) in every cycle without a column command, including right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request queue can accept |
| in_write | input | 1 | 1 = write transaction, 0 = read |
| in_dev | input | DEV_W | Target device |
| in_row | input | ROW_W | Row address |
| in_col1 | input | COL_W | First column address |
| in_col2 | input | COL_W | Second column address |
| row_vld | output | 1 | Activate strobe on the row slot |
| row_dev | output | DEV_W | Activate device |
| row_bank | output | BANK_W | Activate bank |
| row_addr | output | ROW_W | Activate row |
| col_vld | output | 1 | Column command strobe |
| col_op | output | 2 | 0 idle, 1 RD, 2 WR, 3 WRA |
| col_dev | output | DEV_W | Column command device |
| col_bank | output | BANK_W | Column command bank |
| col_addr | output | COL_W | Column address |
| pre_vld | output | 1 | Extended-field precharge strobe (reads) |
| pre_bank | output | BANK_W | Bank being precharged |
| wr_go | output | 1 | Start of a write data packet |
| rd_go | output | 1 | Start of a read data packet |

## Verification
The bench runs the scheduler with `TRC` set longer than four `TRR` slots, so the bank timer limits the fifth activate of each rotation and can be told apart from plain row-to-row pacing. It feeds a run of writes and a run of reads, which separates the two precharge methods and the two data strobes. It then feeds repeated read-read-write-write groups, where only the read-to-write edges must carry the bubble, and a strictly alternating read/write stream, where every other edge carries it. A last request after a long idle pause checks the one-cycle start-up path. Every activate time is predicted from the accept times, the previous activates and the direction history, and every column, precharge and data strobe is predicted from its own activate.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    COL_IDLE = 2'd0,
    COL_RD   = 2'd1,
    COL_WR   = 2'd2,
    COL_WRA  = 2'd3
  } col_op_e;
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  input  logic         pop
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign push_ready = (cnt != (AW+1)'(DEPTH));
  assign head_valid = (cnt != '0);
  assign head_data  = mem[rp];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/sched_dly.sv
module sched_dly #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [D];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[D-1];
endmodule

// File: rtl/ilv_bank_sched.sv
module ilv_bank_sched
  import sched_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int BANK_W = 4,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 6,
  parameter int BASE   = 0,
  parameter int QDEPTH = 4,
  parameter int TRR    = 8,
  parameter int TRC    = 32,
  parameter int TRCD   = 11,
  parameter int TCWD   = 6,
  parameter int TCAC   = 8,
  parameter int TCBUB  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [DEV_W-1:0]  in_dev,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col1,
  input  logic [COL_W-1:0]  in_col2,
  output logic              row_vld,
  output logic [DEV_W-1:0]  row_dev,
  output logic [BANK_W-1:0] row_bank,
  output logic [ROW_W-1:0]  row_addr,
  output logic              col_vld,
  output logic [1:0]        col_op,
  output logic [DEV_W-1:0]  col_dev,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic              pre_vld,
  output logic [BANK_W-1:0] pre_bank,
  output logic              wr_go,
  output logic              rd_go
);
  localparam int NSLOT   = 4;
  localparam int SLOT_W  = 2;
  localparam int TPKT    = TRR / 2;
  localparam int REQ_W   = 1 + DEV_W + ROW_W + 2*COL_W;
  localparam int GAP_MAX = TRR + TCBUB;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int TMR_W   = $clog2(TRC + 1);
  localparam int C1_W    = 2 + DEV_W + BANK_W + 2*COL_W;
  localparam int C2_W    = 2 + DEV_W + BANK_W + COL_W;

  // request queue
  logic             h_valid, issue;
  logic [REQ_W-1:0] h_data;
  logic             h_wr;
  logic [DEV_W-1:0] h_dev;
  logic [ROW_W-1:0] h_row;
  logic [COL_W-1:0] h_c1, h_c2;

  sched_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_ready(in_ready),
    .push_data({in_write, in_dev, in_row, in_col1, in_col2}),
    .head_valid(h_valid), .head_data(h_data), .pop(issue)
  );

  assign {h_wr, h_dev, h_row, h_c1, h_c2} = h_data;

  // issue pacing: rotation slot, spacing counter, direction history, bank timers
  logic [SLOT_W-1:0] slot;
  logic [GAP_W-1:0]  gap, need;
  logic              last_rd;
  logic [TMR_W-1:0]  tmr [NSLOT];
  logic [BANK_W-1:0] bank_sel;
  logic              act_wr;
  logic [COL_W-1:0]  act_c1, act_c2;

  assign need     = (last_rd && h_wr) ? GAP_W'(GAP_MAX) : GAP_W'(TRR);
  assign issue    = h_valid && (gap >= need) && (tmr[slot] == '0);
  assign bank_sel = BANK_W'(BASE) + BANK_W'({slot, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= '0;
      gap      <= GAP_W'(GAP_MAX);
      last_rd  <= 1'b0;
      row_vld  <= 1'b0;
      row_dev  <= '0;
      row_bank <= '0;
      row_addr <= '0;
      act_wr   <= 1'b0;
      act_c1   <= '0;
      act_c2   <= '0;
    end else begin
      row_vld <= issue;
      if (issue) begin
        slot     <= slot + 1'b1;
        gap      <= GAP_W'(1);
        last_rd  <= !h_wr;
        row_dev  <= h_dev;
        row_bank <= bank_sel;
        row_addr <= h_row;
        act_wr   <= h_wr;
        act_c1   <= h_c1;
        act_c2   <= h_c2;
      end else if (gap < GAP_W'(GAP_MAX)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tmr[g] <= '0;
      else if (issue && slot == SLOT_W'(g))  tmr[g] <= TMR_W'(TRC - 1);
      else if (tmr[g] != '0)                 tmr[g] <= tmr[g] - 1'b1;
    end
  end

  // column pipeline: first command TRCD after activate, second TPKT later
  logic              d1_v, d1_wr, d2_v, d2_wr;
  logic [DEV_W-1:0]  d1_dev, d2_dev;
  logic [BANK_W-1:0] d1_bank, d2_bank;
  logic [COL_W-1:0]  d1_c1, d1_c2, d2_c2;

  sched_dly #(.W(C1_W), .D(TRCD)) u_c1 (
    .clk(clk), .rst_n(rst_n),
    .din({row_vld, act_wr, row_dev, row_bank, act_c1, act_c2}),
    .dout({d1_v, d1_wr, d1_dev, d1_bank, d1_c1, d1_c2})
  );

  sched_dly #(.W(C2_W), .D(TPKT)) u_c2 (
    .clk(clk), .rst_n(rst_n),
    .din({d1_v, d1_wr, d1_dev, d1_bank, d1_c2}),
    .dout({d2_v, d2_wr, d2_dev, d2_bank, d2_c2})
  );

  col_op_e op_n;

  always_comb begin
    op_n     = COL_IDLE;
    col_dev  = '0;
    col_bank = '0;
    col_addr = '0;
    if (d1_v) begin
      op_n     = d1_wr ? COL_WR : COL_RD;
      col_dev  = d1_dev;
      col_bank = d1_bank;
      col_addr = d1_c1;
    end else if (d2_v) begin
      op_n     = d2_wr ? COL_WRA : COL_RD;
      col_dev  = d2_dev;
      col_bank = d2_bank;
      col_addr = d2_c2;
    end
  end

  assign col_vld  = d1_v || d2_v;
  assign col_op   = op_n;
  assign pre_vld  = d2_v && !d2_wr;
  assign pre_bank = pre_vld ? d2_bank : '0;

  // data-slot strobes
  logic wcol, rcol;
  assign wcol = (op_n == COL_WR) || (op_n == COL_WRA);
  assign rcol = (op_n == COL_RD);

  sched_dly #(.W(1), .D(TCWD)) u_wd (
    .clk(clk), .rst_n(rst_n), .din(wcol), .dout(wr_go)
  );

  sched_dly #(.W(1), .D(TCAC)) u_rd (
    .clk(clk), .rst_n(rst_n), .din(rcol), .dout(rd_go)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int BANK_W = 4,
  parameter int BASE   = 0,
  parameter int TRR    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_vld,
  input logic [BANK_W-1:0] row_bank,
  input logic              col_vld,
  input logic [1:0]        col_op,
  input logic              pre_vld
);
  localparam int CW = $clog2(TRR + 1);

  logic [CW-1:0] since;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (row_vld) begin
      since <= CW'(1);
      seen  <= 1'b1;
    end else if (since < CW'(TRR)) begin
      since <= since + 1'b1;
    end
  end

  AST_BANK_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |-> (row_bank[0] == 1'(BASE % 2)));                         // R1
  AST_ROW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (row_vld && seen) |-> (since >= CW'(TRR)));                         // R2
  AST_WRA_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && col_op == 2'd3) |-> !pre_vld);                          // R6
  AST_PRE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pre_vld |-> (col_vld && col_op == 2'd1));                           // R7
  AST_COL_IDLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !col_vld |-> (col_op == 2'd0));                                     // R10
endmodule

bind ilv_bank_sched sched_chk #(.BANK_W(BANK_W), .BASE(BASE), .TRR(TRR)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_vld(row_vld), .row_bank(row_bank),
  .col_vld(col_vld), .col_op(col_op), .pre_vld(pre_vld)
);

// File: tb/ilv_bank_sched_test.sv
module ilv_bank_sched_test;
  localparam int DEV_W = 5, BANK_W = 4, ROW_W = 9, COL_W = 6;
  localparam int BASE = 0, TRR = 8, TRC = 40, TRCD = 11, TCWD = 6, TCAC = 8, TCBUB = 4;
  localparam int TPKT = TRR / 2;
  localparam int NE = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_write = 1'b0;
  logic [DEV_W-1:0] in_dev = '0;
  logic [ROW_W-1:0] in_row = '0;
  logic [COL_W-1:0] in_col1 = '0, in_col2 = '0;
  logic in_ready, row_vld, col_vld, pre_vld, wr_go, rd_go;
  logic [DEV_W-1:0] row_dev, col_dev;
  logic [BANK_W-1:0] row_bank, col_bank, pre_bank;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic [1:0] col_op;

  ilv_bank_sched #(.DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .BASE(BASE), .QDEPTH(4), .TRR(TRR), .TRC(TRC), .TRCD(TRCD), .TCWD(TCWD),
    .TCAC(TCAC), .TCBUB(TCBUB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_dev(in_dev), .in_row(in_row), .in_col1(in_col1),
    .in_col2(in_col2), .row_vld(row_vld), .row_dev(row_dev), .row_bank(row_bank),
    .row_addr(row_addr), .col_vld(col_vld), .col_op(col_op), .col_dev(col_dev),
    .col_bank(col_bank), .col_addr(col_addr), .pre_vld(pre_vld), .pre_bank(pre_bank),
    .wr_go(wr_go), .rd_go(rd_go));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0, saw_full = 0;

  int t_wr [64], t_dev [64], t_row [64], t_c1 [64], t_c2 [64], push_c [64], act_c [64];
  int nt = 0, ka = 0;
  int e_op [NE], e_dev [NE], e_bank [NE], e_addr [NE], e_pre [NE], e_pbank [NE], e_wr [NE], e_rd [NE];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic send(input bit wr, input int k);
    in_write = wr;
    in_dev   = DEV_W'(k % 3 + 1);
    in_row   = ROW_W'((k * 37) % 512);
    in_col1  = COL_W'((k * 5) % 64);
    in_col2  = COL_W'((k * 5 + 3) % 64);
    in_valid = 1'b1;
    while (!in_ready) begin
      saw_full = 1;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    t_wr[nt] = wr; t_dev[nt] = k % 3 + 1; t_row[nt] = (k * 37) % 512;
    t_c1[nt] = (k * 5) % 64; t_c2[nt] = (k * 5 + 3) % 64;
    push_c[nt] = cyc;
    nt++;
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ix;
      ix = cyc % NE;
      if (row_vld) begin
        int e, need, c1t, c2t;
        string tag;
        e = push_c[ka] + 1; tag = "R9";
        if (ka > 0) begin
          need = TRR + ((!t_wr[ka-1] && t_wr[ka]) ? TCBUB : 0);
          if (act_c[ka-1] + need >= e) begin
            e = act_c[ka-1] + need;
            tag = (need > TRR) ? "R4" : "R2";
          end
        end
        if (ka >= 4 && act_c[ka-4] + TRC > e) begin
          e = act_c[ka-4] + TRC; tag = "R3";
        end
        chk(cyc == e, {tag, " activate time"}, cyc, e);
        chk(int'(row_bank) == BASE + 2 * (ka % 4), "R1 bank", int'(row_bank), BASE + 2 * (ka % 4));
        chk(int'(row_addr) == t_row[ka] && int'(row_dev) == t_dev[ka], "R1 row/dev",
            int'(row_addr), t_row[ka]);
        act_c[ka] = cyc;
        c1t = cyc + TRCD; c2t = c1t + TPKT;
        e_op[c1t % NE] = t_wr[ka] ? 2 : 1;  e_op[c2t % NE] = t_wr[ka] ? 3 : 1;
        e_dev[c1t % NE] = t_dev[ka];        e_dev[c2t % NE] = t_dev[ka];
        e_bank[c1t % NE] = BASE + 2 * (ka % 4); e_bank[c2t % NE] = BASE + 2 * (ka % 4);
        e_addr[c1t % NE] = t_c1[ka];        e_addr[c2t % NE] = t_c2[ka];
        if (t_wr[ka]) begin
          e_wr[(c1t + TCWD) % NE] = 1; e_wr[(c2t + TCWD) % NE] = 1;
        end else begin
          e_pre[c2t % NE] = 1; e_pbank[c2t % NE] = BASE + 2 * (ka % 4);
          e_rd[(c1t + TCAC) % NE] = 1; e_rd[(c2t + TCAC) % NE] = 1;
        end
        ka++;
      end
      if (col_vld || col_op != 2'd0 || e_op[ix] != 0)
        chk(int'(col_op) == e_op[ix] && col_vld == (e_op[ix] != 0) &&
            (e_op[ix] == 0 || (int'(col_dev) == e_dev[ix] && int'(col_bank) == e_bank[ix] &&
             int'(col_addr) == e_addr[ix])),
            "R5 R6 R7 R10 column op", int'(col_op), e_op[ix]);
      if (pre_vld || e_pre[ix] != 0)
        chk(pre_vld && e_pre[ix] != 0 && int'(pre_bank) == e_pbank[ix],
            "R6 R7 precharge", int'(pre_vld), e_pre[ix]);
      if (wr_go || e_wr[ix] != 0) chk(wr_go == (e_wr[ix] != 0), "R8 wr_go", int'(wr_go), e_wr[ix]);
      if (rd_go || e_rd[ix] != 0) chk(rd_go == (e_rd[ix] != 0), "R8 rd_go", int'(rd_go), e_rd[ix]);
      e_op[ix] = 0; e_pre[ix] = 0; e_wr[ix] = 0; e_rd[ix] = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    report();
  end

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);
    chk(!row_vld && !col_vld && !pre_vld && !wr_go && !rd_go, "R2 idle strobes after reset",
        int'(row_vld | col_vld | pre_vld | wr_go | rd_go), 0);
    chk(col_op == 2'd0, "R10 col_op after reset", int'(col_op), 0);
    for (int i = 0; i < 8; i++) begin send(1'b1, k); k++; end
    for (int i = 0; i < 8; i++) begin send(1'b0, k); k++; end
    for (int g = 0; g < 3; g++) begin
      send(1'b0, k); k++; send(1'b0, k); k++;
      send(1'b1, k); k++; send(1'b1, k); k++;
    end
    for (int i = 0; i < 8; i++) begin send(1'(i % 2), k); k++; end
    repeat (120) @(negedge clk);
    send(1'b1, k); k++;
    repeat (60) @(negedge clk);
    chk(ka == nt, "R9 all requests issued", ka, nt);
    chk(saw_full, "R9 ready dropped with full queue", int'(saw_full), 1);
    done = 1;
    report();
  end
endmodule